// File: doc/BRIEF.md
# Seconds and Sub-Second Real-Time Counter with Alarms

This block keeps time with two counters in a slow 32768 Hz domain. A 15-bit tick counter advances once per slow clock and wraps to zero. The wrap, in the same slow cycle, advances a 32-bit seconds counter. Each counter has its own alarm. An alarm fires either when the counter steps onto the programmed value or on every step of that counter. When its interrupt enable is set, a firing alarm sets a sticky pending flag, and the interrupt output is the OR of the enabled pending flags.

Software reaches the block over a small register bus in the fast core clock domain. Each writable register and each interrupt-clear bit has its own crossing channel. A holding register and a toggle handshake carry the write into the slow domain. The channel shows a busy flag from the write until the slow domain has applied it. Reads come from a snapshot that the slow domain publishes through a second toggle handshake. The seconds value and the tick value always come from the same slow cycle, so a read never shows ticks back at zero while the seconds still hold the old value.

The write side uses valid/ready. A write is taken on a core clock edge where `bus_valid`, `bus_write` and `bus_ready` are all high. `bus_ready` drops only for a write whose target channel is still busy, and the master must then hold the request. Reads are always ready. Read data appears with `bus_rvalid` one core cycle after the read is accepted. The counters have no power-up value. Software clears them through the zero bit in the control register.

Top module: `rtc_timekeeper`

## Requirements
- R1: With the tick run bit (control bit 0) set, the tick counter advances by one on each slow clock and wraps from 0x7FFF to 0. With the bit clear it holds its value.
- R2: When the tick counter wraps and the seconds run bit (control bit 1) is set, the seconds counter advances by one in the same slow cycle. The seconds counter wraps from 0xFFFFFFFF to 0.
- R3: In match mode (control bit 4 for ticks, bit 5 for seconds, clear), a counter stepping onto its alarm value sets that counter's pending flag. This happens only if the counter's interrupt enable is set (control bit 2 for ticks, bit 3 for seconds). A step that does not land on the alarm value sets nothing.
- R4: In every-step mode (the same bits set), each step of the counter sets its pending flag when the interrupt enable is set.
- R5: Pending flags are sticky. They read at address 5, bit 0 for ticks and bit 1 for seconds. `irq` is high exactly while an enabled flag is pending. Events with the enable clear set no flag.
- R6: Writing address 5 with bit 0 or bit 1 set clears the tick or seconds pending flag, and `irq` then falls.
- R7: An accepted write sets that channel's busy bit in status (address 6) on the next core cycle, and the bit clears once the slow domain has applied the write. The busy bits are: bit 0 control, bit 1 seconds, bit 2 ticks, bit 3 seconds alarm, bit 4 tick alarm, bit 5 tick clear, bit 6 seconds clear. Bit 7 is the OR of bits 0 to 6.
- R8: A write to a channel that is still busy sees `bus_ready` low and is not taken. `bus_ready` is high for reads and for writes to idle channels.
- R9: Writing control with bit 6 set zeroes both counters. Bit 6 reads back as 0. Control written as 0 stops both counters, which then keep their values.
- R10: Address 1 reads seconds and address 2 reads ticks, both taken from one slow-cycle snapshot. Addresses 1 to 4 load the seconds counter, the tick counter, the seconds alarm and the tick alarm.
- R11: After reset, control, pending flags and status read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Fast core clock for the register bus |
| rtc_clk | input | 1 | 32768 Hz timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Low while a write targets a busy channel |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after read accept |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, core clock domain |

## Verification
The counters are loaded just below the tick wrap and run for a fixed window. The seconds value then separates a missing carry from a correct one, and a seconds load of all ones shows the 32-bit wrap. The alarms are run with a landing match value, a value the counter never reaches, every-step mode, and the interrupt enable cleared. This tells apart match detection, spurious firing, the mode bit and masking. Back-to-back writes to one register expose the back-pressure, and status reads right after a write show the busy flag rising and then clearing.

// File: rtl/rtc_tk_pkg.sv
package rtc_tk_pkg;
  localparam int AW  = 3;
  localparam int NCH = 7;

  // register addresses
  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_SEC  = 3'd1;
  localparam logic [AW-1:0] A_TICK = 3'd2;
  localparam logic [AW-1:0] A_SALM = 3'd3;
  localparam logic [AW-1:0] A_TALM = 3'd4;
  localparam logic [AW-1:0] A_PEND = 3'd5;
  localparam logic [AW-1:0] A_STAT = 3'd6;

  // crossing channel indices (also status bit positions)
  localparam int CH_CTRL = 0;
  localparam int CH_SEC  = 1;
  localparam int CH_TICK = 2;
  localparam int CH_SALM = 3;
  localparam int CH_TALM = 4;
  localparam int CH_CLRT = 5;
  localparam int CH_CLRS = 6;

  // control bit positions
  localparam int CB_TRUN  = 0;
  localparam int CB_SRUN  = 1;
  localparam int CB_TIE   = 2;
  localparam int CB_SIE   = 3;
  localparam int CB_TEVR  = 4;
  localparam int CB_SEVR  = 5;
  localparam int CB_ZERO  = 6;
  localparam int CTRL_W   = 6;
endpackage

// File: rtl/rtc_post.sv
// One fast-to-slow write channel: holding register plus toggle handshake.
module rtc_post #(
  parameter int W = 32
) (
  input  logic         core_clk,
  input  logic         rtc_clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic         apply_o,
  output logic [W-1:0] data_o
);
  logic req_f, ack_f1, ack_f2;
  logic req_s1, req_s2, req_s3;

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_f  <= 1'b0;
      data_o <= '0;
      ack_f1 <= 1'b0;
      ack_f2 <= 1'b0;
    end else begin
      ack_f1 <= req_s3;
      ack_f2 <= ack_f1;
      if (wr_i) begin
        req_f  <= ~req_f;
        data_o <= wdata_i;
      end
    end
  end

  assign busy_o = req_f ^ ack_f2;

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_s3 <= 1'b0;
    end else begin
      req_s1 <= req_f;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
    end
  end

  assign apply_o = req_s2 ^ req_s3;
endmodule

// File: rtl/rtc_snap.sv
// Slow-to-fast snapshot mailbox: whole word captured in one slow cycle.
module rtc_snap #(
  parameter int W = 49
) (
  input  logic         core_clk,
  input  logic         rtc_clk,
  input  logic         rst_n,
  input  logic [W-1:0] sdata_i,
  output logic [W-1:0] fdata_o
);
  logic [W-1:0] snap;
  logic req_s, ack_s1, ack_s2;
  logic req_f1, req_f2, ack_f;

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      req_s  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_f;
      ack_s2 <= ack_s1;
      if (req_s == ack_s2) begin
        snap  <= sdata_i;
        req_s <= ~req_s;
      end
    end
  end

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_f1  <= 1'b0;
      req_f2  <= 1'b0;
      ack_f   <= 1'b0;
      fdata_o <= '0;
    end else begin
      req_f1 <= req_s;
      req_f2 <= req_f1;
      if (req_f2 != ack_f) begin
        fdata_o <= snap;
        ack_f   <= req_f2;
      end
    end
  end
endmodule

// File: rtl/rtc_counters.sv
// Tick and seconds counters; both update on the same slow edge.
module rtc_counters #(
  parameter int TW = 15,
  parameter int SW = 32
) (
  input  logic          rtc_clk,
  input  logic          zero_i,
  input  logic          ld_tick_i,
  input  logic          ld_sec_i,
  input  logic [TW-1:0] tick_d_i,
  input  logic [SW-1:0] sec_d_i,
  input  logic          tick_run_i,
  input  logic          sec_run_i,
  output logic [TW-1:0] tick_o,
  output logic [SW-1:0] sec_o,
  output logic          tick_step_o,
  output logic          sec_step_o,
  output logic [TW-1:0] tick_nxt_o,
  output logic [SW-1:0] sec_nxt_o
);
  logic wrap;

  assign tick_nxt_o  = tick_o + TW'(1);
  assign sec_nxt_o   = sec_o + SW'(1);
  assign tick_step_o = tick_run_i && !ld_tick_i && !zero_i;
  assign wrap        = tick_step_o && (&tick_o);
  assign sec_step_o  = wrap && sec_run_i && !ld_sec_i;

  // no power-up value: cleared only by the control zero bit
  always_ff @(posedge rtc_clk) begin
    if (zero_i) begin
      tick_o <= '0;
      sec_o  <= '0;
    end else begin
      if (ld_tick_i)        tick_o <= tick_d_i;
      else if (tick_step_o) tick_o <= tick_nxt_o;
      if (ld_sec_i)         sec_o  <= sec_d_i;
      else if (sec_step_o)  sec_o  <= sec_nxt_o;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
// Alarm compare with match / every-step mode and a sticky pending flag.
module rtc_alarm #(
  parameter int W = 15
) (
  input  logic         rtc_clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  input  logic         step_i,
  input  logic [W-1:0] nxt_i,
  input  logic         every_i,
  input  logic         ie_i,
  input  logic         clr_i,
  output logic         pend_o
);
  logic [W-1:0] alm;
  logic         hit;

  assign hit = step_i && ie_i && (every_i || (nxt_i == alm));

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) begin
      alm    <= '0;
      pend_o <= 1'b0;
    end else begin
      if (ld_i) alm <= d_i;
      // a new event in the clearing cycle is kept
      if (hit)        pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_tk_pkg::*;
#(
  parameter int TICK_W = 15,
  parameter int SEC_W  = 32,
  parameter int DW     = 32
) (
  input  logic          core_clk,
  input  logic          rtc_clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_rvalid,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int SNAP_W = SEC_W + TICK_W + 2;

  // ---------------- fast side: write decode ----------------
  logic [NCH-1:0] ch_hit, wr_go, busy, apply;
  logic [DW-1:0]  hold [NCH];
  logic           wr_blocked;

  always_comb begin
    ch_hit = '0;
    if (bus_valid && bus_write) begin
      case (bus_addr)
        A_CTRL: ch_hit[CH_CTRL] = 1'b1;
        A_SEC:  ch_hit[CH_SEC]  = 1'b1;
        A_TICK: ch_hit[CH_TICK] = 1'b1;
        A_SALM: ch_hit[CH_SALM] = 1'b1;
        A_TALM: ch_hit[CH_TALM] = 1'b1;
        A_PEND: begin
          ch_hit[CH_CLRT] = bus_wdata[0];
          ch_hit[CH_CLRS] = bus_wdata[1];
        end
        default: ;
      endcase
    end
  end

  assign wr_blocked = |(ch_hit & busy);
  assign bus_ready  = !wr_blocked;
  assign wr_go      = ch_hit & {NCH{!wr_blocked}};

  for (genvar i = 0; i < NCH; i++) begin : g_post
    rtc_post #(.W(DW)) u_post (
      .core_clk (core_clk),
      .rtc_clk  (rtc_clk),
      .rst_n    (rst_n),
      .wr_i     (wr_go[i]),
      .wdata_i  (bus_wdata),
      .busy_o   (busy[i]),
      .apply_o  (apply[i]),
      .data_o   (hold[i])
    );
  end

  // fast-side shadows for readback
  logic [CTRL_W-1:0] ctrl_sh;
  logic [SEC_W-1:0]  salm_sh;
  logic [TICK_W-1:0] talm_sh;

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_sh <= '0;
      salm_sh <= '0;
      talm_sh <= '0;
    end else begin
      if (wr_go[CH_CTRL]) ctrl_sh <= bus_wdata[CTRL_W-1:0];
      if (wr_go[CH_SALM]) salm_sh <= bus_wdata[SEC_W-1:0];
      if (wr_go[CH_TALM]) talm_sh <= bus_wdata[TICK_W-1:0];
    end
  end

  // ---------------- slow side ----------------
  logic [CTRL_W-1:0] ctrl_s;
  logic              zero_s, ld_tick, ld_sec, clr_t, clr_s;
  logic [TICK_W-1:0] tick_q, tick_nxt;
  logic [SEC_W-1:0]  sec_q, sec_nxt;
  logic              tick_step, sec_step;
  logic [1:0]        pend;
  logic              irq_s, irq_f1;

  assign zero_s  = apply[CH_CTRL] && hold[CH_CTRL][CB_ZERO];
  assign ld_tick = apply[CH_TICK];
  assign ld_sec  = apply[CH_SEC];
  assign clr_t   = apply[CH_CLRT] && hold[CH_CLRT][0];
  assign clr_s   = apply[CH_CLRS] && hold[CH_CLRS][1];

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n)               ctrl_s <= '0;
    else if (apply[CH_CTRL])  ctrl_s <= hold[CH_CTRL][CTRL_W-1:0];
  end

  rtc_counters #(.TW(TICK_W), .SW(SEC_W)) u_cnt (
    .rtc_clk     (rtc_clk),
    .zero_i      (zero_s),
    .ld_tick_i   (ld_tick),
    .ld_sec_i    (ld_sec),
    .tick_d_i    (hold[CH_TICK][TICK_W-1:0]),
    .sec_d_i     (hold[CH_SEC][SEC_W-1:0]),
    .tick_run_i  (ctrl_s[CB_TRUN]),
    .sec_run_i   (ctrl_s[CB_SRUN]),
    .tick_o      (tick_q),
    .sec_o       (sec_q),
    .tick_step_o (tick_step),
    .sec_step_o  (sec_step),
    .tick_nxt_o  (tick_nxt),
    .sec_nxt_o   (sec_nxt)
  );

  rtc_alarm #(.W(TICK_W)) u_talm (
    .rtc_clk (rtc_clk),
    .rst_n   (rst_n),
    .ld_i    (apply[CH_TALM]),
    .d_i     (hold[CH_TALM][TICK_W-1:0]),
    .step_i  (tick_step),
    .nxt_i   (tick_nxt),
    .every_i (ctrl_s[CB_TEVR]),
    .ie_i    (ctrl_s[CB_TIE]),
    .clr_i   (clr_t),
    .pend_o  (pend[0])
  );

  rtc_alarm #(.W(SEC_W)) u_salm (
    .rtc_clk (rtc_clk),
    .rst_n   (rst_n),
    .ld_i    (apply[CH_SALM]),
    .d_i     (hold[CH_SALM][SEC_W-1:0]),
    .step_i  (sec_step),
    .nxt_i   (sec_nxt),
    .every_i (ctrl_s[CB_SEVR]),
    .ie_i    (ctrl_s[CB_SIE]),
    .clr_i   (clr_s),
    .pend_o  (pend[1])
  );

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) irq_s <= 1'b0;
    else        irq_s <= |(pend & {ctrl_s[CB_SIE], ctrl_s[CB_TIE]});
  end

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_f1 <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq_f1 <= irq_s;
      irq    <= irq_f1;
    end
  end

  // ---------------- read path ----------------
  logic [SNAP_W-1:0] snap_f;
  logic [1:0]        pend_f;
  logic [TICK_W-1:0] tick_f;
  logic [SEC_W-1:0]  sec_f;

  rtc_snap #(.W(SNAP_W)) u_snap (
    .core_clk (core_clk),
    .rtc_clk  (rtc_clk),
    .rst_n    (rst_n),
    .sdata_i  ({pend, tick_q, sec_q}),
    .fdata_o  (snap_f)
  );

  assign {pend_f, tick_f, sec_f} = snap_f;

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (bus_addr)
      A_CTRL:  rd_mux = DW'(ctrl_sh);
      A_SEC:   rd_mux = DW'(sec_f);
      A_TICK:  rd_mux = DW'(tick_f);
      A_SALM:  rd_mux = DW'(salm_sh);
      A_TALM:  rd_mux = DW'(talm_sh);
      A_PEND:  rd_mux = DW'(pend_f);
      A_STAT:  rd_mux = DW'({|busy, busy});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end
  end

  logic unused_hold;
  assign unused_hold = ^{hold[CH_CTRL], hold[CH_SEC], hold[CH_TICK], hold[CH_SALM],
                         hold[CH_TALM], hold[CH_CLRT], hold[CH_CLRS]};
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk #(
  parameter int TW  = 15,
  parameter int SW  = 32,
  parameter int NC  = 7
) (
  input logic          core_clk,
  input logic          rtc_clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          bus_ready,
  input logic          bus_rvalid,
  input logic [NC-1:0] wr_go,
  input logic [NC-1:0] busy,
  input logic [TW-1:0] tick_q,
  input logic [SW-1:0] sec_q,
  input logic          tick_run,
  input logic          sec_run,
  input logic          ld_tick,
  input logic          ld_sec,
  input logic          zero_s,
  input logic [1:0]    pend,
  input logic          clr_t,
  input logic          clr_s
);
  // R1
  tick_step_chk: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    (tick_run && !ld_tick && !zero_s) |=> (tick_q == $past(tick_q) + TW'(1)));

  // R2
  carry_same_cycle_chk: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    (tick_run && sec_run && (&tick_q) && !ld_tick && !ld_sec && !zero_s)
      |=> (tick_q == '0 && sec_q == $past(sec_q) + SW'(1)));

  // R9
  zero_bit_chk: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    zero_s |=> (tick_q == '0 && sec_q == '0));

  // R5
  tick_pend_sticky_chk: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    (pend[0] && !clr_t) |=> pend[0]);

  // R5
  sec_pend_sticky_chk: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    (pend[1] && !clr_s) |=> pend[1]);

  // R7
  busy_rise_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
    (|wr_go) |=> ((busy & $past(wr_go)) == $past(wr_go)));

  // R8
  ready_only_writes_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
    !bus_ready |-> (bus_valid && bus_write));

  // R10
  rvalid_follows_read_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write));
endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(.TW(TICK_W), .SW(SEC_W), .NC(rtc_tk_pkg::NCH)) u_chk (
  .core_clk   (core_clk),
  .rtc_clk    (rtc_clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_ready  (bus_ready),
  .bus_rvalid (bus_rvalid),
  .wr_go      (wr_go),
  .busy       (busy),
  .tick_q     (tick_q),
  .sec_q      (sec_q),
  .tick_run   (ctrl_s[rtc_tk_pkg::CB_TRUN]),
  .sec_run    (ctrl_s[rtc_tk_pkg::CB_SRUN]),
  .ld_tick    (ld_tick),
  .ld_sec     (ld_sec),
  .zero_s     (zero_s),
  .pend       (pend),
  .clr_t      (clr_t),
  .clr_s      (clr_s)
);

// File: tb/rtc_timekeeper_tb.sv
`timescale 1ns/1ps
module rtc_timekeeper_tb;
  logic        core_clk = 1'b0;
  logic        rtc_clk  = 1'b0;
  logic        rst_n    = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_rvalid, irq;
  logic [31:0] bus_rdata;

  always #2.5 core_clk = ~core_clk;   // 200 MHz
  always #40  rtc_clk  = ~rtc_clk;    // scaled slow clock

  rtc_timekeeper u_dut (
    .core_clk(core_clk), .rtc_clk(rtc_clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] last_rd = '0;
  logic [31:0] keep;

  // monitor: pops one expected item per returned read
  initial forever begin
    @(posedge core_clk); #2;
    if (bus_rvalid) begin
      if (sbq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL unexpected read data %h", bus_rdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        last_rd = bus_rdata;
        if (it.mask != 0) begin
          n_cmp++;
          if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", it.tag, bus_rdata & it.mask, it.exp & it.mask);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge core_clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin @(negedge core_clk); #1; end
    @(posedge core_clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
    item_t it;
    @(negedge core_clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    it.exp = e; it.mask = m; it.tag = tag;
    sbq.push_back(it);
    @(posedge core_clk); #1;
    bus_valid = 1'b0;
    #2;
  endtask

  task automatic wait_idle(input string tag);
    int guard = 0;
    do begin
      rd(3'd6, 0, 0, "");
      guard++;
    end while (last_rd[7] && guard < 400);
    chk(last_rd[7] == 1'b0, tag, last_rd, 32'h0);
  endtask

  task automatic settle();
    repeat (12) @(posedge rtc_clk);
  endtask

  task automatic slow(input int n);
    repeat (n) @(posedge rtc_clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge core_clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge core_clk);
    rst_n = 1'b1;
    repeat (3) @(posedge core_clk);

    // R11 reset state
    rd(3'd0, 32'h0, 32'hFFFF_FFFF, "R11 ctrl");
    rd(3'd5, 32'h0, 32'hFFFF_FFFF, "R11 pending");
    rd(3'd6, 32'h0, 32'hFFFF_FFFF, "R11 status");
    chk(irq == 1'b0, "R11 irq", {31'd0, irq}, 32'h0);

    // R7 busy rises after accepted write; R9 zero bit
    wr(3'd0, 32'h40);
    rd(3'd6, 32'h81, 32'h81, "R7 ctrl busy set");
    wait_idle("R7 busy cleared");
    settle();
    rd(3'd1, 32'h0, 32'hFFFF_FFFF, "R9 zero sec");
    rd(3'd2, 32'h0, 32'hFFFF_FFFF, "R9 zero tick");
    rd(3'd0, 32'h0, 32'hFFFF_FFFF, "R9 zero bit reads 0");

    // R8 back-pressure on a busy channel
    wr(3'd3, 32'd100);
    @(negedge core_clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd3; bus_wdata = 32'd55;
    #1 chk(bus_ready == 1'b0, "R8 busy target not ready", {31'd0, bus_ready}, 32'h0);
    bus_addr = 3'd6; bus_write = 1'b0;
    #0.5 chk(bus_ready == 1'b1, "R8 read ready", {31'd0, bus_ready}, 32'h1);
    bus_valid = 1'b0;
    wait_idle("R8 idle");
    rd(3'd3, 32'd100, 32'hFFFF_FFFF, "R8 refused write had no effect");

    // R10 loads and readback
    wr(3'd1, 32'd5);
    wr(3'd2, 32'h7FF0);
    wait_idle("R10 load idle");
    settle();
    rd(3'd1, 32'd5, 32'hFFFF_FFFF, "R10 sec load");
    rd(3'd2, 32'h7FF0, 32'hFFFF_FFFF, "R10 tick load");

    // R1/R2 run across the tick wrap
    wr(3'd0, 32'h03);
    slow(40);
    wr(3'd0, 32'h00);
    wait_idle("R1 stop idle");
    settle();
    rd(3'd1, 32'd6, 32'hFFFF_FFFF, "R2 carry into seconds");
    rd(3'd2, 0, 0, "");
    keep = last_rd;
    chk(keep >= 32'd16 && keep <= 32'd32, "R1 tick wrapped and advanced", keep, 32'd24);

    // R9 stopped counters hold
    slow(20);
    rd(3'd2, keep, 32'hFFFF_FFFF, "R9 frozen tick");
    rd(3'd1, 32'd6, 32'hFFFF_FFFF, "R9 frozen sec");

    // R3 tick alarm match, R5 sticky + irq, R6 clear
    wr(3'd2, 32'h100);
    wr(3'd4, 32'h108);
    wait_idle("R3 setup idle");
    wr(3'd0, 32'h05);
    slow(25);
    wr(3'd0, 32'h04);
    wait_idle("R3 stop idle");
    settle();
    rd(3'd5, 32'h1, 32'h3, "R3 tick match pending");
    chk(irq == 1'b1, "R5 irq on enabled pending", {31'd0, irq}, 32'h1);
    slow(10);
    rd(3'd5, 32'h1, 32'h3, "R5 pending sticky");
    wr(3'd5, 32'h1);
    wait_idle("R6 clear idle");
    settle();
    rd(3'd5, 32'h0, 32'h3, "R6 tick pending cleared");
    chk(irq == 1'b0, "R6 irq falls", {31'd0, irq}, 32'h0);

    // R5 masked: enable clear, no pending
    wr(3'd2, 32'h100);
    wait_idle("R5 setup idle");
    wr(3'd0, 32'h01);
    slow(25);
    wr(3'd0, 32'h00);
    wait_idle("R5 stop idle");
    settle();
    rd(3'd5, 32'h0, 32'h3, "R5 masked event not pending");
    chk(irq == 1'b0, "R5 masked irq low", {31'd0, irq}, 32'h0);

    // R3 seconds step that misses the alarm value
    wr(3'd1, 32'd7);
    wr(3'd2, 32'h7FF0);
    wait_idle("R3 miss setup");
    wr(3'd0, 32'h0B);
    slow(40);
    wr(3'd0, 32'h08);
    wait_idle("R3 miss stop");
    settle();
    rd(3'd1, 32'd8, 32'hFFFF_FFFF, "R3 sec stepped");
    rd(3'd5, 32'h0, 32'h3, "R3 no match no pending");

    // R4 every-step mode on seconds
    wr(3'd2, 32'h7FF0);
    wait_idle("R4 setup");
    wr(3'd0, 32'h2B);
    slow(40);
    wr(3'd0, 32'h28);
    wait_idle("R4 stop");
    settle();
    rd(3'd5, 32'h2, 32'h3, "R4 sec every-step pending");
    chk(irq == 1'b1, "R4 irq raised", {31'd0, irq}, 32'h1);
    wr(3'd0, 32'h00);
    wait_idle("R5 unmask idle");
    settle();
    chk(irq == 1'b0, "R5 irq masked by enable", {31'd0, irq}, 32'h0);
    rd(3'd5, 32'h2, 32'h3, "R5 pending kept while masked");
    wr(3'd5, 32'h2);
    wait_idle("R6 sec clear idle");
    settle();
    rd(3'd5, 32'h0, 32'h3, "R6 sec pending cleared");

    // R2 seconds wrap
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h7FF0);
    wait_idle("R2 wrap setup");
    wr(3'd0, 32'h03);
    slow(40);
    wr(3'd0, 32'h00);
    wait_idle("R2 wrap stop");
    settle();
    rd(3'd1, 32'h0, 32'hFFFF_FFFF, "R2 seconds wrap to zero");

    // R4 every-step mode on ticks
    wr(3'd4, 32'h0);
    wait_idle("R4 tick setup");
    wr(3'd0, 32'h15);
    slow(6);
    wr(3'd0, 32'h14);
    wait_idle("R4 tick stop");
    settle();
    rd(3'd5, 32'h1, 32'h3, "R4 tick every-step pending");
    wr(3'd5, 32'h1);
    wait_idle("R6 final clear");
    settle();
    rd(3'd5, 32'h0, 32'h3, "R6 final pending cleared");

    repeat (5) @(posedge core_clk);
    finish_run();
  end
endmodule